// File: doc/BRIEF.md
# Oversampling Conversion Sequencer for an Eight-Channel Simultaneous Sampler

This block controls conversions for an eight-channel converter that samples all channels at the same time. Two active-high start inputs each arm one half of the channels: start A covers channels 1 to 4 and start B covers channels 5 to 8. The two halves may be armed in either order. When both are armed the block raises `busy` and asks the converter core for a set of eight raw 14-bit two's-complement samples. It keeps asking for sets back to back until it has N of them, where N comes from a 3-bit ratio code. It accumulates every channel and then divides by N.

The core is modelled as a request/acknowledge port. `core_req` stays high until `core_ack` is seen, and the eight samples on `core_data` are taken in the acknowledge cycle. The only request tied to the start edge is the first one. Every later request is an internal strobe. The averages are written into a bank of result registers that is separate from the working accumulators. A host reading `rd_data` during a conversion therefore sees the previous results until the new ones are loaded.

Top module: `osr_conv_ctrl`

## Requirements
- R1: A rising edge on `start_a` arms channels 1–4 and a rising edge on `start_b` arms channels 5–8. The edges may come in either order or in the same cycle. A single armed half never starts a conversion.
- R2: `busy` is high at the first falling clock edge after the clock edge that sees the second arming edge. While `busy` is high, edges on either start input are ignored and do not carry over into a later conversion.
- R3: The ratio code selects N = 2^code for codes 0 through 6, that is 1, 2, 4, 8, 16, 32 or 64 request/acknowledge handshakes per conversion.
- R4: A latched code of 7 is run as N = 1 and sets `os_err`. `os_err` stays set until reset.
- R5: The first core request rises together with `busy`. Each later request follows an accepted handshake with no idle cycle between them. `core_req` is only ever high while `busy` is high, and it drops after the N-th acknowledge.
- R6: The result for each channel is the sum of its N samples divided by N, rounded toward negative infinity, as a 14-bit two's-complement value. The result occupies bits [15:2] of its 16-bit word and bits [1:0] are zero. Sample i sits at `core_data[14*i +: 14]`.
- R7: The ratio code is sampled only at the clock edge where `busy` falls, and it governs the next conversion. Changes to the code at any other time have no effect. After reset the ratio is 1.
- R8: The result registers change at the clock edge one cycle before `busy` falls and at no other edge. During a conversion, until that edge, reads return the previous results.
- R9: With every acknowledge given in the cycle its request is presented, `busy` stays high for exactly N+1 clock cycles.
- R10: An active-high reset aborts a conversion at once. It lowers `busy` and `core_req`, clears every result word and `os_err`, drops any armed half, and sets the ratio back to 1.
- R11: `rd_data` shows the result word of channel `rd_sel`+1, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| start_a | input | 1 | Start for channels 1–4, acts on its rising edge |
| start_b | input | 1 | Start for channels 5–8, acts on its rising edge |
| os_code | input | 3 | Oversampling ratio code, sampled when busy falls |
| core_ack | input | 1 | Core acknowledge, samples valid in this cycle |
| core_data | input | 112 | Eight packed 14-bit raw samples |
| rd_sel | input | 3 | Channel select for the read port |
| busy | output | 1 | Conversion in progress |
| core_req | output | 1 | Request for one set of core samples |
| rd_data | output | 16 | Selected result word, result in [15:2] |
| os_err | output | 1 | Sticky flag: invalid ratio code was latched |

## Verification
The hardest situation to reach from the ports is the boundary between buffers. The new results must already be readable in the last busy cycle, while the cycle before must still show the old ones, and the ratio code must change in mid-conversion without taking effect. The stimulus reads all eight channels on every busy cycle and compares the last two snapshots with the previous and the new expected words. During one conversion it moves the ratio code to a decoy value and then to the intended one, and it re-pulses both starts. A slow core that acknowledges every other cycle stretches a 32-sample conversion, and a reset arrives halfway through a 16-sample run.

// File: rtl/osr_pkg.sv
package osr_pkg;

  localparam int OS_CODE_W = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_UPD  = 2'd2
  } seq_state_t;

  // Code 7 is not a legal ratio: it is run as ratio 1.
  function automatic logic os_bad(input logic [OS_CODE_W-1:0] code);
    return code == 3'b111;
  endfunction

  // log2 of the oversampling ratio selected by a code.
  function automatic logic [OS_CODE_W-1:0] os_shift(input logic [OS_CODE_W-1:0] code);
    return os_bad(code) ? 3'd0 : code;
  endfunction

endpackage

// File: rtl/osr_start_arm.sv
module osr_start_arm (
  input  logic clk,
  input  logic rst,
  input  logic start_a,
  input  logic start_b,
  input  logic busy,
  output logic go,
  output logic arm_a,
  output logic arm_b
);
  logic prev_a, prev_b;
  logic rise_a, rise_b;
  logic eff_a, eff_b;

  assign rise_a = start_a & ~prev_a;
  assign rise_b = start_b & ~prev_b;
  // Edges seen while busy never arm a half.
  assign eff_a  = arm_a | (rise_a & ~busy);
  assign eff_b  = arm_b | (rise_b & ~busy);
  assign go     = eff_a & eff_b & ~busy;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
      arm_a  <= 1'b0;
      arm_b  <= 1'b0;
    end else begin
      prev_a <= start_a;
      prev_b <= start_b;
      arm_a  <= (go | busy) ? 1'b0 : eff_a;
      arm_b  <= (go | busy) ? 1'b0 : eff_b;
    end
  end
endmodule

// File: rtl/osr_seq.sv
module osr_seq
  import osr_pkg::*;
#(
  parameter int LOG_MAX = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic [OS_CODE_W-1:0] os_code,
  input  logic                 core_ack,
  output logic                 busy,
  output logic                 core_req,
  output logic                 take,
  output logic                 last_take,
  output logic                 int_strobe,
  output logic [OS_CODE_W-1:0] ratio_log,
  output logic                 os_err
);
  seq_state_t        state;
  logic [LOG_MAX-1:0] cnt;
  logic [LOG_MAX-1:0] cnt_last;

  assign busy       = (state != SEQ_IDLE);
  assign cnt_last   = LOG_MAX'((32'd1 << ratio_log) - 32'd1);
  assign take       = core_req & core_ack;
  assign last_take  = take & (cnt == cnt_last);
  // Every request after the first comes from this internal strobe.
  assign int_strobe = take & ~last_take;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      core_req  <= 1'b0;
      cnt       <= '0;
      ratio_log <= '0;
      os_err    <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (go) begin
            state    <= SEQ_CONV;
            core_req <= 1'b1;
            cnt      <= '0;
          end
        end
        SEQ_CONV: begin
          if (last_take) begin
            state    <= SEQ_UPD;
            core_req <= 1'b0;
          end else if (take) begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_UPD: begin
          state     <= SEQ_IDLE;
          ratio_log <= os_shift(os_code);
          os_err    <= os_err | os_bad(os_code);
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/osr_chan_acc.sv
module osr_chan_acc
  import osr_pkg::*;
#(
  parameter int SAMP_W  = 14,
  parameter int LOG_MAX = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 take,
  input  logic                 last_take,
  input  logic [SAMP_W-1:0]    sample,
  input  logic [OS_CODE_W-1:0] shift,
  output logic [SAMP_W+1:0]    word
);
  localparam int ACC_W = SAMP_W + LOG_MAX;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] sum_next;

  // Arithmetic shift: floor division by the power-of-two ratio.
  function automatic logic [SAMP_W-1:0] avg_of(input logic signed [ACC_W-1:0] s,
                                               input logic [OS_CODE_W-1:0] sh);
    logic signed [ACC_W-1:0] t;
    t = s >>> sh;
    return t[SAMP_W-1:0];
  endfunction

  assign sum_next = acc + $signed({{LOG_MAX{sample[SAMP_W-1]}}, sample});

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      acc  <= '0;
      word <= '0;
    end else begin
      if (clr)       acc <= '0;
      else if (take) acc <= sum_next;
      if (last_take) word <= {avg_of(sum_next, shift), 2'b00};
    end
  end
endmodule

// File: rtl/osr_conv_ctrl.sv
module osr_conv_ctrl
  import osr_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int SAMP_W  = 14,
  parameter int LOG_MAX = 6,
  parameter int SEL_W   = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_a,
  input  logic                  start_b,
  input  logic [OS_CODE_W-1:0]  os_code,
  input  logic                  core_ack,
  input  logic [NCH*SAMP_W-1:0] core_data,
  input  logic [SEL_W-1:0]      rd_sel,
  output logic                  busy,
  output logic                  core_req,
  output logic [SAMP_W+1:0]     rd_data,
  output logic                  os_err
);
  localparam int WORD_W = SAMP_W + 2;
  localparam int FLAT_W = NCH * WORD_W;

  logic                 go, arm_a, arm_b;
  logic                 take, last_take, int_strobe;
  logic [OS_CODE_W-1:0] ratio_log;
  logic [WORD_W-1:0]    res_w [NCH];
  logic [FLAT_W-1:0]    res_flat;

  osr_start_arm u_arm (
    .clk(clk), .rst(rst), .start_a(start_a), .start_b(start_b),
    .busy(busy), .go(go), .arm_a(arm_a), .arm_b(arm_b)
  );

  osr_seq #(.LOG_MAX(LOG_MAX)) u_seq (
    .clk(clk), .rst(rst), .go(go), .os_code(os_code), .core_ack(core_ack),
    .busy(busy), .core_req(core_req), .take(take), .last_take(last_take),
    .int_strobe(int_strobe), .ratio_log(ratio_log), .os_err(os_err)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    osr_chan_acc #(.SAMP_W(SAMP_W), .LOG_MAX(LOG_MAX)) u_acc (
      .clk(clk), .rst(rst), .clr(go), .take(take), .last_take(last_take),
      .sample(core_data[i*SAMP_W +: SAMP_W]), .shift(ratio_log),
      .word(res_w[i])
    );
    assign res_flat[i*WORD_W +: WORD_W] = res_w[i];
  end

  assign rd_data = res_w[rd_sel];
endmodule

// File: rtl/osr_conv_chk.sv
module osr_conv_chk #(
  parameter int FLAT_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              go,
  input logic              arm_a,
  input logic              arm_b,
  input logic              core_req,
  input logic              int_strobe,
  input logic              last_take,
  input logic              os_err,
  input logic [FLAT_W-1:0] res_flat
);
  // R2
  busy_from_go_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go));
  // R2
  no_arm_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!arm_a && !arm_b));
  // R5
  req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    core_req |-> busy);
  // R5
  strobe_reissue_chk: assert property (@(posedge clk) disable iff (rst)
    int_strobe |=> core_req);
  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    last_take |=> !core_req);
  // R8
  load_before_fall_chk: assert property (@(posedge clk) disable iff (rst)
    last_take |=> (busy ##1 !busy));
  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !last_take |=> $stable(res_flat));
  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    os_err |=> os_err);
endmodule

bind osr_conv_ctrl osr_conv_chk #(.FLAT_W(FLAT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .go(go), .arm_a(arm_a), .arm_b(arm_b),
  .core_req(core_req), .int_strobe(int_strobe), .last_take(last_take),
  .os_err(os_err), .res_flat(res_flat)
);

// File: tb/tb_osr_conv_ctrl.sv
`timescale 1ns/10ps
module tb_osr_conv_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_a = 1'b0, start_b = 1'b0;
  logic [2:0]   os_code = 3'd0;
  logic         core_ack = 1'b0;
  logic [111:0] core_data = '0;
  logic [2:0]   rd_sel = 3'd0;
  logic         busy, core_req, os_err;
  logic [15:0]  rd_data;

  int n_chk = 0, n_fail = 0;
  int conv_idx = 0, k_idx = 0;
  bit slow = 1'b0, phase = 1'b0, busy_m = 1'b0;
  int cur_n = 1;
  bit exp_err = 1'b0;
  int           exp_n_q [$];
  logic [127:0] exp_w_q [$];
  logic [127:0] last_words = '0;

  always #2 clk = ~clk;

  osr_conv_ctrl dut (
    .clk(clk), .rst(rst), .start_a(start_a), .start_b(start_b), .os_code(os_code),
    .core_ack(core_ack), .core_data(core_data), .rd_sel(rd_sel),
    .busy(busy), .core_req(core_req), .rd_data(rd_data), .os_err(os_err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  function automatic int samp(int c, int k, int ch);
    if (ch == 0) return -8192;
    if (ch == 7) return 8191;
    return ((c * 977 + k * 613 + ch * 2311) % 16384) - 8192;
  endfunction

  // Expected words for the next conversion: floor of the mean.
  task automatic expect_conv(input int n);
    logic [127:0] w;
    for (int ch = 0; ch < 8; ch++) begin
      int sum = 0;
      int avg;
      for (int k = 0; k < n; k++) sum += samp(conv_idx, k, ch);
      avg = sum / n;
      if (sum < 0 && (sum % n) != 0) avg = avg - 1;
      w[ch*16 +: 16] = {14'(avg), 2'b00};
    end
    exp_n_q.push_back(n);
    exp_w_q.push_back(w);
  endtask

  task automatic read_all(output logic [127:0] v);
    for (int ch = 0; ch < 8; ch++) begin
      rd_sel = 3'(ch);
      #0.2;
      v[ch*16 +: 16] = rd_data;
    end
  endtask

  // Core model: acknowledge requests, serve deterministic samples.
  always @(negedge clk) begin
    if (rst) begin
      core_ack = 1'b0;
      k_idx = 0;
    end else begin
      if (core_ack) k_idx++;
      if (!busy) k_idx = 0;
      phase = ~phase;
      if (core_req && (!slow || phase)) begin
        core_ack = 1'b1;
        for (int ch = 0; ch < 8; ch++) core_data[ch*14 +: 14] = 14'(samp(conv_idx, k_idx, ch));
      end else core_ack = 1'b0;
    end
    if (busy_m && !busy) conv_idx++;
    busy_m = busy;
  end

  // Monitor / scoreboard.
  logic [127:0] snap1, snap2, now_w, exp_w;
  int  blen = 0;
  bit  bq = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      bq = 1'b0; blen = 0; last_words = '0;
    end else begin
      if (busy) begin
        blen++;
        snap2 = snap1;
        read_all(snap1);
        // R8: reads during the first busy cycle return the previous results
        if (!bq) check(snap1 == last_words, "R8 old data at busy start", snap1, last_words);
      end else if (bq) begin
        read_all(now_w);
        if (exp_w_q.size() == 0) begin
          check(1'b0, "R6 unexpected conversion", 0, 1);
        end else begin
          int n;
          n = exp_n_q.pop_front();
          exp_w = exp_w_q.pop_front();
          // R6 R11: averaged words per channel
          check(now_w == exp_w, "R6 R11 averaged results", now_w, exp_w);
          // R8: loaded one cycle before busy fell
          check(snap1 == exp_w, "R8 results in last busy cycle", snap1, exp_w);
          if (blen >= 2) check(snap2 == last_words, "R8 previous results held", snap2, last_words);
          // R3 R9: busy length N+1 with prompt acknowledges
          if (!slow) check(blen == n + 1, "R3 R9 busy length", blen, n + 1);
        end
        last_words = now_w;
        blen = 0;
      end
      bq = busy;
    end
  end

  task automatic fire(input int gap);
    if (gap >= 0) begin
      start_a = 1'b1;
      repeat (gap) @(negedge clk);
      start_b = 1'b1;
    end else begin
      start_b = 1'b1;
      repeat (-gap) @(negedge clk);
      start_a = 1'b1;
    end
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!busy && guard < 2000) begin @(negedge clk); guard++; end
    while (busy && guard < 2000) begin @(negedge clk); guard++; end
    // R7: code latched at the fall governs the next conversion
    cur_n = (os_code == 3'd7) ? 1 : (1 << os_code);
    if (os_code == 3'd7) exp_err = 1'b1;
    // R4
    check(os_err == exp_err, "R4 error flag", os_err, exp_err);
  endtask

  task automatic drop_starts();
    start_a = 1'b0; start_b = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [127:0] v;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0, "R10 busy in reset", busy, 0);
    check(core_req == 1'b0, "R10 req in reset", core_req, 0);
    check(os_err == 1'b0, "R10 err in reset", os_err, 0);
    read_all(v);
    check(v == '0, "R10 R11 results cleared", v, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1: one half armed alone does nothing
    os_code = 3'd3;
    expect_conv(cur_n);
    start_a = 1'b1;
    repeat (6) @(negedge clk);
    check(busy == 1'b0, "R1 single half no start", busy, 0);
    check(core_req == 1'b0, "R1 single half no request", core_req, 0);
    start_b = 1'b1;
    @(negedge clk);
    // R2 R5: busy and first request one cycle after the second edge
    check(busy == 1'b1, "R2 busy after second edge", busy, 1);
    check(core_req == 1'b1, "R5 first request with busy", core_req, 1);
    wait_done();
    drop_starts();

    // R2 R7: B first; start pulses and a decoy code during busy
    os_code = 3'd2;
    expect_conv(cur_n);
    fire(-3);
    while (!busy) @(negedge clk);
    start_a = 1'b0; start_b = 1'b0;
    @(negedge clk);
    start_a = 1'b1; start_b = 1'b1; os_code = 3'd1;
    @(negedge clk);
    os_code = 3'd5;
    wait_done();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(busy == 1'b0, "R2 edges during busy ignored", busy, 0);
    end
    drop_starts();

    // R3 R5: slow core, same-cycle edges
    slow = 1'b1;
    os_code = 3'd6;
    expect_conv(cur_n);
    fire(0);
    wait_done();
    drop_starts();
    slow = 1'b0;

    // R3 R4: ratio 64, then invalid code latched
    os_code = 3'd7;
    expect_conv(cur_n);
    fire(2);
    wait_done();
    drop_starts();

    // R4: invalid code runs as ratio 1, flag stays set
    os_code = 3'd4;
    expect_conv(cur_n);
    fire(0);
    wait_done();
    drop_starts();

    // R10: reset in the middle of a 16-sample conversion
    fire(0);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R10 abort busy", busy, 0);
    check(core_req == 1'b0, "R10 abort request", core_req, 0);
    check(os_err == 1'b0, "R10 error cleared", os_err, 0);
    read_all(v);
    check(v == '0, "R10 results cleared on abort", v, 0);
    start_a = 1'b0; start_b = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cur_n = 1; exp_err = 1'b0;
    @(negedge clk);

    // R7 R10: ratio back to 1 after reset although code 4 was present
    os_code = 3'd0;
    expect_conv(cur_n);
    fire(1);
    wait_done();
    drop_starts();
    repeat (3) @(negedge clk);
    check(exp_w_q.size() == 0, "R6 all conversions seen", exp_w_q.size(), 0);
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end
endmodule